// File: doc/BRIEF.md
# Peripheral Clock-Stop and Reset Control Bank

This block keeps the per-peripheral reset and clock-stop state of a chip in flip-flops behind a simple register bus. It has 64 reset bits and 64 clock-stop bits. Each group is split into two 32-bit banks. Bit index `i` lives in bank `i / 32`, at bit position `i % 32`.

Every bank can be reached at two word addresses:
- Writing to the lower (set) address sets each bit that is 1 in the write data.
- Writing to the upper (clear) address, four bytes higher, clears each bit that is 1 in the write data.
- Bits that are 0 in the write data keep their value.

The block drives two 64-bit vectors:
- `resetVec`, where a 1 holds the peripheral in reset.
- `clkEnVec`, where a 1 means that peripheral's clock runs. The per-bit polarity of the stop bits is already applied, so the consumer reads a plain enable.

A separate control word holds a select bit. This bit chooses whether the UART reference is 24 MHz divided by 13 or the undivided 24 MHz.

Top module: `periph_gate_bank`

## Requirements
- R1: After reset, `resetVec` is all ones and `uartDiv13Sel` is 0. `clkEnVec` equals 64'h0000_0004_0000_0061, so only clocks 0, 5, 6 and 34 run.
- R2: A write to a set address ORs the write data into that bank. The set addresses are 0x040 (reset 0–31), 0x050 (reset 32–63), 0x080 (clock-stop 0–31) and 0x090 (clock-stop 32–63). Data bits that are 0 leave their bit unchanged. The outputs show the new value right after the clock edge that takes the write.
- R3: A write to a clear address (set address + 0x4) clears every bank bit whose data bit is 1 and leaves the others unchanged. The outputs update on the same edge as in R2.
- R4: Index `i` maps to bank `i/32`, bit `i%32`. Bit 3 of the write data at 0x050 is therefore reset ID 35 (`resetVec[35]`). Bit 2 at 0x090 is clock index 34.
- R5: For every clock index except 14, a 1 in the stop bit gives `clkEnVec[i]`=0. For index 14, a 1 in the stop bit gives `clkEnVec[14]`=1.
- R6: A read returns the bank contents on `busRdData`. This holds for both the set and the clear address of a bank. The value appears right after the clock edge on which `busRdEn` is high, and is held until the next read.
- R7: Offset 0x0C0 is a plainly written control word. Write bit 12 drives `uartDiv13Sel`. A read of 0x0C0 returns that bit at position 12 and zeros elsewhere.
- R8: Writes to any other offset change no output and no register. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address of the access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Registered read data |
| resetVec | output | 64 | Per-peripheral reset, 1 = held in reset |
| clkEnVec | output | 64 | Per-peripheral clock enable, polarity applied |
| uartDiv13Sel | output | 1 | UART reference divide-by-13 select |

## Verification
- **Write results:** `resetVec`, `clkEnVec` and `uartDiv13Sel` change on the first rising edge after the write strobe is presented. The bench drives each access on a falling edge and samples the outputs on the next falling edge, half a cycle after the edge that took the write.
- **Read results:** read data passes through one register. The bench samples `busRdData` on the falling edge after the edge on which `busRdEn` was high.
- **Reference model:** after every access the bench compares both vectors with a 64-bit model. The model is updated from the requirement encodings alone.

// File: rtl/gate_bank_pkg.sv
package gate_bank_pkg;

  parameter int ADDR_W         = 12;
  parameter int DATA_W         = 32;
  parameter int BANKS_PER_KIND = 2;
  localparam int NUM_REGS      = 2 * BANKS_PER_KIND;
  localparam int TOTAL_W       = BANKS_PER_KIND * DATA_W;

  localparam logic [ADDR_W-1:0] RST_BASE    = 12'h040;
  localparam logic [ADDR_W-1:0] STOP_BASE   = 12'h080;
  localparam logic [ADDR_W-1:0] BANK_STRIDE = 12'h010;
  localparam logic [ADDR_W-1:0] CLR_ALIAS   = 12'h004;
  localparam logic [ADDR_W-1:0] MISC_OFS    = 12'h0C0;
  localparam int                MISC_BIT    = 12;

  // Registers 0..BANKS_PER_KIND-1 hold reset bits, the rest hold clock-stop bits.
  typedef struct packed {
    logic [NUM_REGS-1:0] setEn;
    logic [NUM_REGS-1:0] clrEn;
    logic                miscWr;
    logic [NUM_REGS-1:0] rdBank;
    logic                rdMisc;
    logic                rdEn;
  } bankStrobe_t;

  function automatic logic [ADDR_W-1:0] regOffset(input int r);
    if (r < BANKS_PER_KIND)
      return RST_BASE + ADDR_W'(r) * BANK_STRIDE;
    else
      return STOP_BASE + ADDR_W'(r - BANKS_PER_KIND) * BANK_STRIDE;
  endfunction

endpackage

// File: rtl/gate_bank_ctrl.sv
module gate_bank_ctrl
  import gate_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output bankStrobe_t       strobe
);

  logic [NUM_REGS-1:0] setHit;
  logic [NUM_REGS-1:0] clrHit;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_decode
    assign setHit[r] = (busAddr == regOffset(r));
    assign clrHit[r] = (busAddr == (regOffset(r) + CLR_ALIAS));
  end

  always_comb begin
    strobe.setEn  = busWrEn ? setHit : '0;
    strobe.clrEn  = busWrEn ? clrHit : '0;
    strobe.miscWr = busWrEn && (busAddr == MISC_OFS);
    strobe.rdBank = busRdEn ? (setHit | clrHit) : '0;
    strobe.rdMisc = busRdEn && (busAddr == MISC_OFS);
    strobe.rdEn   = busRdEn;
  end

  // R8: at most one register is targeted by a write
  p_one_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setEn, strobe.clrEn, strobe.miscWr}));

  // R6: a read never selects more than one source
  p_one_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rdBank, strobe.rdMisc}));

endmodule

// File: rtl/gate_bank_datapath.sv
module gate_bank_datapath
  import gate_bank_pkg::*;
#(
  parameter int                 INV_IDX   = 14,
  parameter logic [TOTAL_W-1:0] CRIT_MASK = 64'h0000_0004_0000_0061
)(
  input  logic               clk,
  input  logic               rstN,
  input  bankStrobe_t        strobe,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [TOTAL_W-1:0] resetVec,
  output logic [TOTAL_W-1:0] clkEnVec,
  output logic               uartSel
);

  localparam logic [TOTAL_W-1:0] INV_MASK  = TOTAL_W'(1) << INV_IDX;
  localparam logic [TOTAL_W-1:0] STOP_INIT = ~(CRIT_MASK ^ INV_MASK);

  logic [DATA_W-1:0]  bankQ [NUM_REGS];
  logic [TOTAL_W-1:0] stopVec;
  logic               miscQ;
  logic [DATA_W-1:0]  rdMux;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_bank
    localparam logic [DATA_W-1:0] INIT = (r < BANKS_PER_KIND) ? '1 :
      STOP_INIT[(r - BANKS_PER_KIND) * DATA_W +: DATA_W];

    always_ff @(posedge clk) begin
      if (!rstN)                 bankQ[r] <= INIT;
      else if (strobe.clrEn[r])  bankQ[r] <= bankQ[r] & ~wrData;
      else if (strobe.setEn[r])  bankQ[r] <= bankQ[r] | wrData;
    end

    // R2: every data bit written to a set address is 1 afterwards
    p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.setEn[r] |=> ((bankQ[r] & $past(wrData)) == $past(wrData)));
    // R3: every data bit written to a clear address is 0 afterwards
    p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clrEn[r] |=> ((bankQ[r] & $past(wrData)) == '0));
    // R2/R3: bits outside the data mask keep their value
    p_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.setEn[r] || strobe.clrEn[r]) |=>
        ((bankQ[r] & ~$past(wrData)) == ($past(bankQ[r]) & ~$past(wrData))));

    if (r < BANKS_PER_KIND) begin : g_rst
      assign resetVec[r*DATA_W +: DATA_W] = bankQ[r];
    end else begin : g_stop
      assign stopVec[(r-BANKS_PER_KIND)*DATA_W +: DATA_W] = bankQ[r];
    end
  end

  assign clkEnVec = ~stopVec ^ INV_MASK;

  always_ff @(posedge clk) begin
    if (!rstN)              miscQ <= 1'b0;
    else if (strobe.miscWr) miscQ <= wrData[MISC_BIT];
  end
  assign uartSel = miscQ;

  always_comb begin
    rdMux = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (strobe.rdBank[r]) rdMux = rdMux | bankQ[r];
    if (strobe.rdMisc) rdMux[MISC_BIT] = miscQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= rdMux;
  end

  // R7: the select follows bit 12 of the control-word write
  p_misc_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.miscWr |=> (uartSel == $past(wrData[MISC_BIT])));

  // R8: unmapped reads return zero
  p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && !(|strobe.rdBank) && !strobe.rdMisc) |=> (rdData == '0));

  // R6: read data holds between reads
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rdData));

endmodule

// File: rtl/periph_gate_bank.sv
module periph_gate_bank
  import gate_bank_pkg::*;
#(
  parameter int                 INV_IDX   = 14,
  parameter logic [TOTAL_W-1:0] CRIT_MASK = 64'h0000_0004_0000_0061
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               busRdEn,
  output logic [DATA_W-1:0]  busRdData,
  output logic [TOTAL_W-1:0] resetVec,
  output logic [TOTAL_W-1:0] clkEnVec,
  output logic               uartDiv13Sel
);

  bankStrobe_t strobe;

  gate_bank_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe)
  );

  gate_bank_datapath #(
    .INV_IDX   (INV_IDX),
    .CRIT_MASK (CRIT_MASK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .resetVec (resetVec),
    .clkEnVec (clkEnVec),
    .uartSel  (uartDiv13Sel)
  );

  // R8: no write means no output change
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(resetVec) && $stable(clkEnVec) && $stable(uartDiv13Sel)));

endmodule

// File: tb/periph_gate_bank_tb.sv
module periph_gate_bank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic [63:0] resetVec;
  logic [63:0] clkEnVec;
  logic        uartDiv13Sel;

  int checks = 0;
  int failures = 0;

  logic [63:0] rstM;
  logic [63:0] stopM;
  logic        miscM;

  always #10 clk = ~clk;

  periph_gate_bank u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .resetVec(resetVec), .clkEnVec(clkEnVec), .uartDiv13Sel(uartDiv13Sel)
  );

  function automatic logic [63:0] expEn(input logic [63:0] stop);
    return ~stop ^ (64'd1 << 14);
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    case (a)
      12'h040, 12'h044: return rstM[31:0];
      12'h050, 12'h054: return rstM[63:32];
      12'h080, 12'h084: return stopM[31:0];
      12'h090, 12'h094: return stopM[63:32];
      12'h0C0:          return {19'd0, miscM, 12'd0};
      default:          return 32'd0;
    endcase
  endfunction

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h040: rstM[31:0]   = rstM[31:0]   | d;
      12'h044: rstM[31:0]   = rstM[31:0]   & ~d;
      12'h050: rstM[63:32]  = rstM[63:32]  | d;
      12'h054: rstM[63:32]  = rstM[63:32]  & ~d;
      12'h080: stopM[31:0]  = stopM[31:0]  | d;
      12'h084: stopM[31:0]  = stopM[31:0]  & ~d;
      12'h090: stopM[63:32] = stopM[63:32] | d;
      12'h094: stopM[63:32] = stopM[63:32] & ~d;
      12'h0C0: miscM = d[12];
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkOutputs(input string tag);
    chk({tag, " resetVec"}, resetVec, rstM);
    chk({tag, " clkEnVec"}, clkEnVec, expEn(stopM));
    chk({tag, " uartDiv13Sel"}, {63'd0, uartDiv13Sel}, {63'd0, miscM});
  endtask

  // drive on falling edge, write taken on next rising edge, sample on following falling edge
  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic busRead(input logic [11:0] a, input string tag);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    chk(tag, {32'd0, busRdData}, {32'd0, expRead(a)});
  endtask

  localparam int NUM_OFS = 12;
  function automatic logic [11:0] pickAddr(input int k);
    case (k)
      0: return 12'h040;  1: return 12'h044;  2: return 12'h050;  3: return 12'h054;
      4: return 12'h080;  5: return 12'h084;  6: return 12'h090;  7: return 12'h094;
      8: return 12'h0C0;  9: return 12'h048; 10: return 12'h0C4;
      default: return 12'($urandom_range(0, 4095)) & 12'hFFC;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rstM = '1;
    stopM = ~(64'h0000_0004_0000_0061 ^ (64'd1 << 14));
    miscM = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 resetVec", resetVec, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1 clkEnVec", clkEnVec, 64'h0000_0004_0000_0061);
    chk("R1 uartDiv13Sel", {63'd0, uartDiv13Sel}, 64'd0);

    // R3 clear reset ID 35 via upper alias; R4 bank mapping
    busWrite(12'h054, 32'h0000_0008);
    chk("R4 resetVec[35] cleared", {63'd0, resetVec[35]}, 64'd0);
    chkOutputs("R3 clear");

    // R2 set with zero data changes nothing
    busWrite(12'h050, 32'h0);
    chkOutputs("R2 zero data");
    busWrite(12'h050, 32'h0000_0008);
    chk("R2 resetVec[35] set", {63'd0, resetVec[35]}, 64'd1);

    // R5 inverted polarity at index 14
    busWrite(12'h080, 32'h0000_4000);
    chk("R5 clkEnVec[14] on", {63'd0, clkEnVec[14]}, 64'd1);
    busWrite(12'h084, 32'h0000_0020);
    chk("R5 clkEnVec[5] on after stop clear", {63'd0, clkEnVec[5]}, 64'd1);
    busWrite(12'h080, 32'h0000_0020);
    chk("R5 clkEnVec[5] off after stop set", {63'd0, clkEnVec[5]}, 64'd0);
    // R4 clock index 34
    busWrite(12'h090, 32'h0000_0004);
    chk("R4 clkEnVec[34] off", {63'd0, clkEnVec[34]}, 64'd0);
    chkOutputs("R4 after index 34");

    // R6 reads on both addresses
    busRead(12'h080, "R6 read stop bank0");
    busRead(12'h084, "R6 read clear alias");
    busRead(12'h054, "R6 read reset alias");
    @(negedge clk);
    chk("R6 hold", {32'd0, busRdData}, {32'd0, expRead(12'h054)});

    // R7 misc word
    busWrite(12'h0C0, 32'hFFFF_FFFF);
    chk("R7 select set", {63'd0, uartDiv13Sel}, 64'd1);
    busRead(12'h0C0, "R7 read misc");
    busWrite(12'h0C0, 32'hFFFF_EFFF);
    chk("R7 select clear", {63'd0, uartDiv13Sel}, 64'd0);

    // R8 unmapped
    busWrite(12'h048, 32'hFFFF_FFFF);
    chkOutputs("R8 unmapped write");
    busWrite(12'h100, 32'hFFFF_FFFF);
    chkOutputs("R8 unmapped write 0x100");
    busRead(12'h048, "R8 unmapped read");

    // random mix, R2 R3 R6 R8
    for (int i = 0; i < 400; i++) begin
      int k;
      logic [11:0] a;
      k = int'($urandom_range(0, NUM_OFS - 1));
      a = pickAddr(k);
      if ($urandom_range(0, 2) == 0) begin
        busRead(a, "R6 random read");
      end else begin
        busWrite(a, $urandom());
        chkOutputs("R2/R3 random write");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule